// File: doc/BRIEF.md
# Transmit Inter-Frame Gap Timer

This block spaces out transmitted Ethernet frames. After a frame has left the wire, or after the transmit path has dropped into its idle state, it counts bit times up to a programmed gap length. A pending transmit request is held back until that count is reached. A request that shows up after the gap has already run out is let through in the same clock cycle.

The count advances on a one-cycle bit-time tick supplied by the surrounding MAC. The gap length is programmed in bit times, for example 96 down to 64 in steps of 8. In half-duplex operation the block also watches carrier sense and splits the gap into two regions:

- Carrier seen in the early region, up to and including floor(2*gap/3), throws the count back to zero.
- Carrier seen in the late third is disregarded, and the frame goes out once the gap completes.

A frame is taken as started in any cycle where the request and the grant are both high. It is taken as ended when the end/idle event arrives. Collision backoff and serialization are handled elsewhere.

Top module: `tx_gap_timer`

## Requirements
- R1: While reset is held and just after it, no frame is in progress and the gap count is zero. The grant is therefore low for any nonzero gap length and high for a gap length of zero.
- R2: Outside a frame, the count rises by one in each cycle where `bit_tick` is high, and it stops at the programmed gap length.
- R3: The grant is high exactly when no frame is in progress and the count has reached the gap length. With the request held high, the grant first appears after exactly `gap_bits` ticks counted from the end/idle event.
- R4: When the count is already saturated, a request that rises is granted in that same cycle, with no added latency.
- R5: A frame starts in a cycle where `tx_req` and `tx_grant` are both high. From the next cycle until an end/idle event, the grant stays low and ticks have no effect.
- R6: An end/idle event (`tx_end_idle` high for a cycle) ends any frame and restarts the count from zero.
- R7: In half-duplex (`half_duplex`=1), carrier sense in a cycle where the count is at most floor(2*gap/3) and below the gap reloads the count to zero. A carrier pulse at count k then delays the grant to k+gap ticks. Carrier sense wins over a tick in the same cycle.
- R8: In half-duplex, carrier sense while the count is above floor(2*gap/3) is ignored, and the grant still appears after gap ticks.
- R9: In full-duplex (`half_duplex`=0), carrier sense has no effect on the count or the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_bits | input | GAP_W | Programmed gap length in bit times |
| half_duplex | input | 1 | 1 = half-duplex deferral rules apply |
| tx_end_idle | input | 1 | One-cycle pulse: frame finished, or transmit path went idle |
| carrier_sense | input | 1 | Carrier present on the medium |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_req | input | 1 | Frame pending for transmission |
| tx_grant | output | 1 | Gap satisfied and no frame in progress |

## Verification
The bench builds the block with GAP_W=5, so every gap length from 0 to 31 can be swept in both duplex modes. For each gap length and mode, a single carrier pulse is placed at every count from 0 to the gap. This covers both sides of the floor(2*gap/3) boundary, including the boundary count itself and the degenerate gaps of 0, 1 and 2. Each sweep point measures the number of ticks to the grant and compares it with gap or k+gap. Gaps that end saturated also exercise same-cycle grant of a late request, and ticks applied during a frame.

// File: rtl/tx_gap_pkg.sv
package tx_gap_pkg;
  typedef enum logic {
    PH_GAP   = 1'b0,
    PH_FRAME = 1'b1
  } tx_phase_e;
endpackage

// File: rtl/tx_gap_thresh.sv
module tx_gap_thresh #(
  parameter int GAP_W = 7
) (
  input  logic [GAP_W-1:0] gap_bits,
  output logic [GAP_W-1:0] early_lim
);
  localparam int WIDE_W = GAP_W + 1;
  logic [WIDE_W-1:0] twice;
  logic [WIDE_W-1:0] third;

  always_comb begin
    twice     = {gap_bits, 1'b0};
    third     = twice / WIDE_W'(3);
    early_lim = third[GAP_W-1:0];
  end
endmodule

// File: rtl/tx_gap_phase.sv
module tx_gap_phase
  import tx_gap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      end_evt,
  output tx_phase_e phase
);
  tx_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_GAP:   if (start)   phase_d = PH_FRAME;
      PH_FRAME: if (end_evt) phase_d = PH_GAP;
      default:               phase_d = PH_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_GAP;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R5
  frame_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FRAME && !end_evt) |=> (phase_q == PH_FRAME));
endmodule

// File: rtl/tx_gap_counter.sv
module tx_gap_counter #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_bits,
  input  logic             clear,
  input  logic             restart,
  input  logic             tick,
  output logic [GAP_W-1:0] count,
  output logic             at_gap
);
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign at_gap = (cnt_q >= gap_bits);

  always_comb begin
    cnt_en = clear || restart || (tick && !at_gap);
    cnt_d  = cnt_q;
    if (clear || restart) cnt_d = '0;
    else if (tick && !at_gap) cnt_d = cnt_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_gap && !clear && !restart) |=> (cnt_q == GAP_W'($past(cnt_q) + 1)));
  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_gap && !clear && !restart) |=> (cnt_q == $past(cnt_q)));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || restart) |=> (cnt_q == '0));
endmodule

// File: rtl/tx_gap_timer.sv
module tx_gap_timer
  import tx_gap_pkg::*;
#(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap_bits,
  input  logic             half_duplex,
  input  logic             tx_end_idle,
  input  logic             carrier_sense,
  input  logic             bit_tick,
  input  logic             tx_req,
  output logic             tx_grant
);
  tx_phase_e        phase;
  logic [GAP_W-1:0] count;
  logic [GAP_W-1:0] early_lim;
  logic             at_gap;
  logic             in_gap;
  logic             start;
  logic             clear;
  logic             restart;

  assign in_gap   = (phase == PH_GAP);
  assign tx_grant = in_gap && at_gap;
  assign start    = tx_grant && tx_req;
  assign clear    = start || tx_end_idle || !in_gap;
  assign restart  = half_duplex && carrier_sense && in_gap && !at_gap &&
                    (count <= early_lim);

  tx_gap_thresh #(.GAP_W(GAP_W)) u_thresh (
    .gap_bits  (gap_bits),
    .early_lim (early_lim)
  );

  tx_gap_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .end_evt (tx_end_idle),
    .phase   (phase)
  );

  tx_gap_counter #(.GAP_W(GAP_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .gap_bits (gap_bits),
    .clear    (clear),
    .restart  (restart),
    .tick     (bit_tick),
    .count    (count),
    .at_gap   (at_gap)
  );

  // R5
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_grant && !tx_end_idle) |=> !tx_grant);
  // R7
  early_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex && carrier_sense && !tx_grant && !tx_end_idle &&
     (count <= early_lim) && (phase == PH_GAP)) |=> (count == '0));
  // R8
  late_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex && carrier_sense && !bit_tick && !tx_end_idle && !tx_req &&
     (count > early_lim)) |=> (count == $past(count)));
  // R9
  fd_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_duplex && tx_grant && !tx_req && !tx_end_idle &&
     $stable(gap_bits)) |=> tx_grant);
endmodule

// File: tb/tx_gap_timer_tb.sv
module tx_gap_timer_tb;
  localparam int GAP_W = 5;
  localparam int GMAX  = (1 << GAP_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [GAP_W-1:0] gap_bits;
  logic             half_duplex, tx_end_idle, carrier_sense, bit_tick, tx_req;
  logic             tx_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tx_gap_timer #(.GAP_W(GAP_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .gap_bits      (gap_bits),
    .half_duplex   (half_duplex),
    .tx_end_idle   (tx_end_idle),
    .carrier_sense (carrier_sense),
    .bit_tick      (bit_tick),
    .tx_req        (tx_req),
    .tx_grant      (tx_grant)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_end_idle   = 1'b0;
    carrier_sense = 1'b0;
    bit_tick      = 1'b0;
    tx_req        = 1'b0;
  endtask

  // One sweep point: gap g, mode hd, carrier pulse placed when k ticks have passed.
  task automatic run(input int g, input bit hd, input int k);
    int  ticks;
    bit  crs_done;
    bit  early;
    int  expt;
    @(negedge clk);
    idle_inputs();
    gap_bits    = GAP_W'(g);
    half_duplex = hd;
    tx_end_idle = 1'b1;                     // R6 restart from zero
    @(negedge clk);
    idle_inputs();
    ticks    = 0;
    crs_done = 1'b0;
    for (int i = 0; i < 4 * GMAX + 8; i++) begin
      if (tx_grant) break;
      idle_inputs();
      if (!crs_done && ticks == k) begin
        carrier_sense = 1'b1;
        if (k % 2 == 1) bit_tick = 1'b1;  // R7 carrier beats tick when restarting
        crs_done = 1'b1;
        early = hd && (k <= (2 * g) / 3) && (k < g);
        if (!early && bit_tick) ticks++;
      end else begin
        bit_tick = 1'b1;
        ticks++;
      end
      @(negedge clk);
    end
    idle_inputs();
    early = hd && crs_done && (k <= (2 * g) / 3) && (k < g);
    expt  = early ? k + g : g;
    if (early)      check("R7 ticks to grant", ticks, expt);
    else if (hd)    check("R8 ticks to grant", ticks, expt);
    else            check("R9/R3 ticks to grant", ticks, expt);
    // R2 saturation: extra ticks keep grant
    bit_tick = 1'b1;
    repeat (3) @(negedge clk);
    bit_tick = 1'b0;
    check("R2 saturated grant", int'(tx_grant), 1);
    // R4 late request granted at once
    tx_req = 1'b1;
    #1;
    check("R4 same-cycle grant", int'(tx_grant), 1);
    @(negedge clk);
    tx_req   = 1'b0;
    bit_tick = 1'b1;
    check("R5 grant low in frame", int'(tx_grant), 0);
    repeat (g + 2) @(negedge clk);
    bit_tick = 1'b0;
    check("R5 ticks ignored in frame", int'(tx_grant), 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    gap_bits    = GAP_W'(12);
    half_duplex = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 grant low in reset", int'(tx_grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grant low after reset", int'(tx_grant), 0);
    gap_bits = '0;
    #1;
    check("R1 zero gap grants", int'(tx_grant), 1);
    // R6: end event mid-count restarts
    gap_bits = GAP_W'(6);
    tx_req   = 1'b1;
    bit_tick = 1'b1;
    repeat (4) @(negedge clk);
    bit_tick    = 1'b0;
    tx_end_idle = 1'b1;
    @(negedge clk);
    tx_end_idle = 1'b0;
    bit_tick    = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 restart delays grant", int'(tx_grant), 0);
    @(negedge clk);
    bit_tick = 1'b0;
    check("R3 grant after full gap", int'(tx_grant), 1);
    idle_inputs();
    for (int g = 0; g <= GMAX; g++)
      for (int hd = 0; hd < 2; hd++)
        for (int k = 0; k <= g; k++)
          run(g, hd[0], k);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule